// File: doc/BRIEF.md
# Suspend Duty Controller

This block throttles a processor core by driving an active-low suspend request in a repeating pattern. The pattern has two phases: an asserted phase, in which the core idles, and a released phase, in which it runs. Each phase lasts a programmed number of 32 µs ticks. With `onLen` asserted ticks and `offLen` released ticks, the core runs at `offLen / (offLen + onLen)` of its full frequency.

Software programs the block through a byte-wide write port. The port carries the two phase lengths, an enable bit, a power-management enable byte, and reload values for two hold-off timers. One timer serves interrupt activity and the other serves video activity. While either timer is counting, the suspend request is held released, so the core runs at full speed while it services that activity. A prescaler divides the system clock down to the 32 µs tick. A second prescaler divides that tick down to the coarse unit used by the hold-off timers.

New phase lengths are picked up only at a phase boundary, so a phase that is already running is never cut short.

Top module: `susp_duty_ctrl`

## Requirements
- R1: After reset all registers are zero, modulation is disabled and `suspReqN` is high.
- R2: With modulation enabled and both lengths nonzero, `suspReqN` is low for `onLen` ticks and high for `offLen` ticks, repeating. One tick is `TICK_CYCLES` clock cycles. Over any window of whole periods, the low time is `onLen*TICK_CYCLES` cycles per period.
- R3: Bit 0 of the configuration register at address 0x96 enables modulation. When that bit is clear, `suspReqN` stays high.
- R4: If `onLen` is zero, `suspReqN` never goes low. If `offLen` is zero and `onLen` is nonzero, it stays low. If both are zero, it stays high.
- R5: A write to a phase length takes effect only at the next phase boundary. The phase that is running finishes at its old length.
- R6: The interrupt hold-off is armed when power-management bits 0 and 3 at address 0x80 are both set. While it is armed, each `irqEvent` loads the timer at 0x8C. Each load restarts a timer that is already running. The timer counts down once per `MS_TICKS` ticks. While it is nonzero, `suspReqN` is forced high.
- R7: The video hold-off works the same way. It needs power-management bits 0 and 4, is triggered by `vidEvent`, and reloads from address 0x8D.
- R8: The OFF length is written at address 0x94 and the ON length at 0x95. Writes to any other unlisted address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 8 | Register write address |
| cfgWrData | input | 8 | Register write data |
| irqEvent | input | 1 | Interrupt activity pulse |
| vidEvent | input | 1 | Video activity pulse |
| suspReqN | output | 1 | Active-low suspend request to the core |

## Verification
The bench builds the block with `TICK_CYCLES` = 4 and `MS_TICKS` = 3. At these values one tick is four cycles and one hold-off unit is twelve cycles. With that scaling, several whole modulation periods fit into a few hundred cycles, and a hold-off can be seen to start, to restart and to expire within a short directed test. Duty is measured by counting the low cycles over a window of exactly three periods. That count does not depend on where in the pattern the window starts.

// File: rtl/susp_pkg.sv
package susp_pkg;

  // Register addresses (decoded by the write port)
  localparam logic [7:0] ADDR_PMEN    = 8'h80;
  localparam logic [7:0] ADDR_IRQ_RLD = 8'h8C;
  localparam logic [7:0] ADDR_VID_RLD = 8'h8D;
  localparam logic [7:0] ADDR_OFF_LEN = 8'h94;
  localparam logic [7:0] ADDR_ON_LEN  = 8'h95;
  localparam logic [7:0] ADDR_CFG     = 8'h96;

  // Bit positions
  localparam int PM_GLOBAL_BIT = 0;
  localparam int PM_IRQ_BIT    = 3;
  localparam int PM_VID_BIT    = 4;
  localparam int CFG_EN_BIT    = 0;

  localparam int NUM_HOLDOFF = 2;

  // Strobes and lengths passed from control to datapath
  typedef struct packed {
    logic       tick;
    logic       modEn;
    logic       speedup;
    logic [7:0] onLen;
    logic [7:0] offLen;
  } ctlStrobes_t;

endpackage

// File: rtl/susp_holdoff_timer.sv
module susp_holdoff_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] reload,
  input  logic             msTick,
  output logic             active
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (arm) begin
      remain <= reload;
    end else if (msTick && (remain != '0)) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign active = (remain != '0);

endmodule

// File: rtl/susp_ctrl.sv
module susp_ctrl
  import susp_pkg::*;
#(
  parameter int TICK_CYCLES = 1066,
  parameter int MS_TICKS    = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        irqEvent,
  input  logic        vidEvent,
  output ctlStrobes_t strb
);

  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int MW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);
  localparam logic [MW-1:0] MS_LAST   = MW'(MS_TICKS - 1);

  // Register file
  logic       modEnReg;
  logic       pmGlobal, pmIrq, pmVid;
  logic [7:0] offReg, onReg;
  logic [7:0] rldArr [NUM_HOLDOFF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modEnReg <= 1'b0;
      pmGlobal <= 1'b0;
      pmIrq    <= 1'b0;
      pmVid    <= 1'b0;
      offReg   <= '0;
      onReg    <= '0;
      rldArr[0] <= '0;
      rldArr[1] <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PMEN: begin
          pmGlobal <= wrData[PM_GLOBAL_BIT];
          pmIrq    <= wrData[PM_IRQ_BIT];
          pmVid    <= wrData[PM_VID_BIT];
        end
        ADDR_IRQ_RLD: rldArr[0] <= wrData;
        ADDR_VID_RLD: rldArr[1] <= wrData;
        ADDR_OFF_LEN: offReg    <= wrData;
        ADDR_ON_LEN:  onReg     <= wrData;
        ADDR_CFG:     modEnReg  <= wrData[CFG_EN_BIT];
        default: ;
      endcase
    end
  end

  // 32 us tick prescaler
  logic [TW-1:0] tickCnt;
  logic          tick;
  assign tick = (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + TW'(1);
  end

  // Coarse hold-off unit prescaler, counts ticks
  logic [MW-1:0] msCnt;
  logic          msTick;
  assign msTick = tick && (msCnt == MS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msCnt <= '0;
    else if (msTick) msCnt <= '0;
    else if (tick)   msCnt <= msCnt + MW'(1);
  end

  // Hold-off timers: index 0 interrupt, index 1 video
  logic [NUM_HOLDOFF-1:0] armVec;
  logic [NUM_HOLDOFF-1:0] actVec;

  assign armVec[0] = irqEvent && pmGlobal && pmIrq;
  assign armVec[1] = vidEvent && pmGlobal && pmVid;

  for (genvar g = 0; g < NUM_HOLDOFF; g++) begin : g_holdoff
    susp_holdoff_timer #(.CNT_W(8)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (armVec[g]),
      .reload (rldArr[g]),
      .msTick (msTick),
      .active (actVec[g])
    );
  end

  assign strb.tick    = tick;
  assign strb.modEn   = modEnReg;
  assign strb.speedup = |actVec;
  assign strb.onLen   = onReg;
  assign strb.offLen  = offReg;

endmodule

// File: rtl/susp_datapath.sv
module susp_datapath
  import susp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctlStrobes_t strb,
  output logic        suspReqN
);

  logic       phaseOn;
  logic [7:0] remCnt;
  logic       boundary;
  logic       nextOn;
  logic [7:0] nextLen;

  assign boundary = strb.tick && (remCnt <= 8'd1);

  // Phase selection at a boundary; zero-length phases are skipped
  always_comb begin
    nextOn  = 1'b0;
    nextLen = '0;
    if (phaseOn) begin
      if (strb.offLen != '0) begin
        nextOn = 1'b0; nextLen = strb.offLen;
      end else if (strb.onLen != '0) begin
        nextOn = 1'b1; nextLen = strb.onLen;
      end
    end else begin
      if (strb.onLen != '0) begin
        nextOn = 1'b1; nextLen = strb.onLen;
      end else if (strb.offLen != '0) begin
        nextOn = 1'b0; nextLen = strb.offLen;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseOn <= 1'b0;
      remCnt  <= '0;
    end else if (!strb.modEn) begin
      phaseOn <= 1'b0;
      remCnt  <= '0;
    end else if (boundary) begin
      phaseOn <= nextOn;
      remCnt  <= nextLen;
    end else if (strb.tick) begin
      remCnt  <= remCnt - 8'd1;
    end
  end

  assign suspReqN = !(phaseOn && strb.modEn && !strb.speedup);

endmodule

// File: rtl/susp_duty_ctrl.sv
module susp_duty_ctrl
  import susp_pkg::*;
#(
  parameter int TICK_CYCLES = 1066,
  parameter int MS_TICKS    = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgAddr,
  input  logic [7:0] cfgWrData,
  input  logic       irqEvent,
  input  logic       vidEvent,
  output logic       suspReqN
);

  ctlStrobes_t ctlStrb;

  susp_ctrl #(
    .TICK_CYCLES (TICK_CYCLES),
    .MS_TICKS    (MS_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (cfgWrEn),
    .wrAddr   (cfgAddr),
    .wrData   (cfgWrData),
    .irqEvent (irqEvent),
    .vidEvent (vidEvent),
    .strb     (ctlStrb)
  );

  susp_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (ctlStrb),
    .suspReqN (suspReqN)
  );

endmodule

// File: rtl/susp_duty_chk.sv
module susp_duty_chk (
  input logic clk,
  input logic rst_n,
  input logic suspReqN,
  input logic tick,
  input logic modEn,
  input logic speedup
);

  // R3
  mod_off_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !modEn |-> suspReqN);

  // R6
  speedup_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    speedup |-> suspReqN);

  // R2
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspReqN) |-> $past(tick));

  // R2
  rise_on_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspReqN) |-> ($past(tick) || speedup || !modEn));

endmodule

bind susp_duty_ctrl susp_duty_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .suspReqN (suspReqN),
  .tick     (ctlStrb.tick),
  .modEn    (ctlStrb.modEn),
  .speedup  (ctlStrb.speedup)
);

// File: tb/susp_duty_ctrl_tb.sv
`timescale 1ns/1ps
module susp_duty_ctrl_tb;

  localparam int TICK = 4;
  localparam int MSU  = 3;

  // {offLen, onLen}
  localparam logic [15:0] VEC [8] = '{
    {8'd3, 8'd2}, {8'd1, 8'd1}, {8'd5, 8'd7}, {8'd0, 8'd4},
    {8'd4, 8'd0}, {8'd0, 8'd0}, {8'd10, 8'd1}, {8'd2, 8'd9}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       irqEvent = 1'b0;
  logic       vidEvent = 1'b0;
  logic       suspReqN;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  susp_duty_ctrl #(.TICK_CYCLES(TICK), .MS_TICKS(MSU)) u_dut (
    .clk, .rst_n, .cfgWrEn, .cfgAddr, .cfgWrData, .irqEvent, .vidEvent, .suspReqN
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic countLow(input int window, output int lows);
    lows = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (!suspReqN) lows++;
    end
  endtask

  task automatic pulseIrq();
    @(negedge clk); irqEvent = 1'b1;
    @(negedge clk); irqEvent = 1'b0;
  endtask

  task automatic pulseVid();
    @(negedge clk); vidEvent = 1'b1;
    @(negedge clk); vidEvent = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nTests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int lows, win, expLow, off, on, run;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(suspReqN === 1'b1, "R1 reset level", int'(suspReqN), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: registers zero, so nothing asserts after reset
    countLow(40, lows);
    check(lows == 0, "R1 idle after reset", lows, 0);

    // R3: counts programmed but enable clear
    wrReg(8'h94, 8'd2); wrReg(8'h95, 8'd5);
    countLow(60, lows);
    check(lows == 0, "R3 disabled held high", lows, 0);

    // R2/R4: vector table
    for (int v = 0; v < 8; v++) begin
      off = int'(VEC[v][15:8]);
      on  = int'(VEC[v][7:0]);
      wrReg(8'h96, 8'h00);
      wrReg(8'h94, VEC[v][15:8]);
      wrReg(8'h95, VEC[v][7:0]);
      wrReg(8'h96, 8'h01);
      repeat (40) @(negedge clk);
      win = ((on + off) == 0) ? 48 : 3 * (on + off) * TICK;
      if (on == 0)       expLow = 0;
      else if (off == 0) expLow = win;
      else               expLow = 3 * on * TICK;
      countLow(win, lows);
      check(lows == expLow, (on == 0 || off == 0) ? "R4 zero length" : "R2 duty", lows, expLow);
    end

    // R8: writes to unlisted addresses leave off=3 on=2 unchanged
    wrReg(8'h96, 8'h00); wrReg(8'h94, 8'd3); wrReg(8'h95, 8'd2); wrReg(8'h96, 8'h01);
    wrReg(8'h97, 8'hFF); wrReg(8'h93, 8'hFF); wrReg(8'h96, 8'h01);
    repeat (40) @(negedge clk);
    countLow(60, lows);
    check(lows == 24, "R8 unlisted address ignored", lows, 24);

    // R3: clearing enable releases immediately
    wrReg(8'h96, 8'h00);
    @(negedge clk);
    check(suspReqN === 1'b1, "R3 clear enable", int'(suspReqN), 1);

    // R5: mid-phase write of ON length
    wrReg(8'h94, 8'd4); wrReg(8'h95, 8'd4); wrReg(8'h96, 8'h01);
    repeat (40) @(negedge clk);
    while (!suspReqN) @(negedge clk);
    while (suspReqN) @(negedge clk);
    run = 1;
    forever begin
      @(negedge clk);
      if (run == 2) begin cfgWrEn = 1'b1; cfgAddr = 8'h95; cfgWrData = 8'd1; end
      else cfgWrEn = 1'b0;
      if (suspReqN) break;
      run++;
    end
    cfgWrEn = 1'b0;
    check(run == 4 * TICK, "R5 running phase kept", run, 4 * TICK);
    run = 0;
    while (suspReqN) begin run++; @(negedge clk); end
    check(run == 4 * TICK, "R5 off phase length", run, 4 * TICK);
    run = 0;
    while (!suspReqN) begin run++; @(negedge clk); end
    check(run == 1 * TICK, "R5 new on length", run, TICK);

    // R6: interrupt hold-off, always-asserted pattern
    wrReg(8'h96, 8'h00); wrReg(8'h94, 8'd0); wrReg(8'h95, 8'd8); wrReg(8'h96, 8'h01);
    wrReg(8'h80, 8'h19); wrReg(8'h8C, 8'd2); wrReg(8'h8D, 8'd1);
    repeat (20) @(negedge clk);
    check(suspReqN === 1'b0, "R6 baseline asserted", int'(suspReqN), 0);
    pulseIrq();
    check(suspReqN === 1'b1, "R6 irq forces release", int'(suspReqN), 1);
    repeat (9) @(negedge clk);
    check(suspReqN === 1'b1, "R6 irq hold-off held", int'(suspReqN), 1);
    repeat (25) @(negedge clk);
    check(suspReqN === 1'b0, "R6 irq hold-off expires", int'(suspReqN), 0);
    // R6: retrigger restarts the timer
    pulseIrq();
    repeat (19) @(negedge clk);
    pulseIrq();
    repeat (10) @(negedge clk);
    check(suspReqN === 1'b1, "R6 retrigger extends", int'(suspReqN), 1);
    repeat (30) @(negedge clk);
    // R6: irq bit clear, or global bit clear, disarms
    wrReg(8'h80, 8'h11);
    pulseIrq();
    check(suspReqN === 1'b0, "R6 irq bit clear ignored", int'(suspReqN), 0);
    wrReg(8'h80, 8'h18);
    pulseIrq();
    check(suspReqN === 1'b0, "R6 global clear ignored", int'(suspReqN), 0);

    // R7: video hold-off
    pulseVid();
    check(suspReqN === 1'b0, "R7 global clear ignored", int'(suspReqN), 0);
    wrReg(8'h80, 8'h19);
    pulseVid();
    check(suspReqN === 1'b1, "R7 video forces release", int'(suspReqN), 1);
    repeat (20) @(negedge clk);
    check(suspReqN === 1'b0, "R7 video hold-off expires", int'(suspReqN), 0);
    wrReg(8'h80, 8'h09);
    pulseVid();
    check(suspReqN === 1'b0, "R7 video bit clear ignored", int'(suspReqN), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule